// File: doc/BRIEF.md
# Multichannel Conversion Scan Sequencer

This block is the digital control half of a multiplexed analog-to-digital converter. It walks a 19-bit channel-enable mask one channel at a time. For each enabled channel it runs a sample phase and then a conversion phase, and it produces one aligned result word per channel. A sequence can be started by a software pulse or by an edge on a hardware trigger input, and it can scan upward or downward through the mask. It either stops after one pass or wraps around and repeats until a stop command arrives. The analog core is abstracted: the currently selected channel number is presented on `cur_chan`, and the environment returns that channel's 12-bit full-scale value on `sample_in`.

The controller has three states. IDLE waits for a start. SAMPLE counts the sample window. CONVERT counts the conversion window. The transitions are:
- start: IDLE to SAMPLE, on a start request with a non-empty mask.
- sample-done: SAMPLE to CONVERT.
- next-channel: CONVERT to SAMPLE, when another enabled channel follows in scan order.
- wrap: CONVERT to SAMPLE at the first channel, when the pass is finished and continuous mode is on.
- finish: CONVERT to IDLE, when the pass is finished in single mode.
- stop: SAMPLE or CONVERT to IDLE, when `sw_stop` is asserted.

The mask and the scan direction are captured at the start transition and hold for the whole run. Four sticky flags report progress: sample end, result ready, sequence end and overrun. Each flag has its own enable into a single interrupt line. When a flag is set and cleared in the same cycle, the set wins.

Top module: `scan_seq_ctrl`

## Requirements
- R1: After reset `busy`, `irq`, all four flags and `data_out` are 0.
- R2: With `cfg_scan_down`=0, only channels whose mask bit is set are converted, in ascending channel order (mask bit i is channel i).
- R3: With `cfg_scan_down`=1, the enabled channels are converted in descending channel order.
- R4: The sample phase lasts 3, 15, 27, 57, 83, 111, 143 or 479 clocks for `cfg_smp_code` 0 to 7. The conversion phase lasts 28, 26, 22 or 18 clocks for `cfg_res` 00, 01, 10 or 11. `flag_eosmp` sets S clocks after the start edge and `flag_eoc` sets S+C clocks after it.
- R5: The result keeps the top n bits of `sample_in`, where n is 12, 10, 8 or 6 for `cfg_res` 00 to 11. With `cfg_left_align`=0 these bits sit at bit 0 of `data_out`. With `cfg_left_align`=1 their top bit sits at bit 15.
- R6: `cfg_trig_mode` 00 ignores `hw_trig`. Mode 01 starts a run on a rising edge, 10 on a falling edge and 11 on either edge.
- R7: With `cfg_cont`=0 one pass is made and `busy` falls after the last result. With `cfg_cont`=1 the scan restarts at the first enabled channel.
- R8: `sw_stop` returns the block to idle at the next edge, and no further result follows.
- R9: A result that completes while `flag_eoc` is still set sets `flag_ovr`. It leaves `data_out` unchanged when `cfg_ovr_overwrite`=0 and replaces it when `cfg_ovr_overwrite`=1.
- R10: A `rd_data` pulse clears `flag_eoc`. Writing 1 to `flag_clr` bit 0, 1 or 2 clears `flag_eosmp`, `flag_eos` or `flag_ovr` respectively, and leaves the other flags as they are.
- R11: `irq` is set when any flag is set together with its `irq_en` bit (bit 0 sample end, 1 result ready, 2 sequence end, 3 overrun).
- R12: A start request while `busy` is ignored. A start with an all-zero mask sets only `flag_eos` and leaves the block idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (one tick is half a converter cycle) |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mask | input | 19 | Channel enable mask |
| cfg_scan_down | input | 1 | 1 selects descending scan order |
| cfg_trig_mode | input | 2 | Hardware trigger edge select |
| cfg_res | input | 2 | Resolution code |
| cfg_smp_code | input | 3 | Sample window code |
| cfg_cont | input | 1 | Continuous (repeating) scan |
| cfg_ovr_overwrite | input | 1 | 1 lets a new result replace an unread one |
| cfg_left_align | input | 1 | 1 left-aligns the result |
| irq_en | input | 4 | Per-flag interrupt enables |
| sw_start | input | 1 | Software start pulse |
| sw_stop | input | 1 | Stop pulse |
| hw_trig | input | 1 | Hardware trigger level |
| rd_data | input | 1 | Result read strobe |
| flag_clr | input | 3 | Write-1-to-clear for sample end, sequence end and overrun |
| sample_in | input | 12 | Full-scale value of the selected channel |
| cur_chan | output | 5 | Channel being sampled or converted |
| busy | output | 1 | A scan is running |
| data_out | output | 16 | Aligned result word |
| flag_eosmp | output | 1 | Sample phase ended |
| flag_eoc | output | 1 | Result ready |
| flag_eos | output | 1 | Sequence ended |
| flag_ovr | output | 1 | Overrun |
| irq | output | 1 | Interrupt request |

## Verification
Starting from the clock edge that accepts a start, the sample-end flag is due after exactly S edges and the first result after S+C edges. Each following result arrives one S+C period later, and a stop or trigger shows on `busy` one edge after it is sampled. The bench drives inputs and samples outputs on falling edges and advances a fixed number of them to the exact edge where a result is due. It checks that flags are still clear one edge early and are set on the due edge, so a one-cycle slip in either counter is caught. Reads and flag clears are one-clock strobes, and their cycles are counted into the next wait.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

    localparam int TICK_W = 9;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SAMPLE  = 2'd1,
        ST_CONVERT = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        TRIG_OFF  = 2'b00,
        TRIG_RISE = 2'b01,
        TRIG_FALL = 2'b10,
        TRIG_BOTH = 2'b11
    } trig_mode_e;

    // sample window in half-cycle ticks
    function automatic logic [TICK_W-1:0] smp_ticks(input logic [2:0] code);
        case (code)
            3'd0:    smp_ticks = TICK_W'(3);
            3'd1:    smp_ticks = TICK_W'(15);
            3'd2:    smp_ticks = TICK_W'(27);
            3'd3:    smp_ticks = TICK_W'(57);
            3'd4:    smp_ticks = TICK_W'(83);
            3'd5:    smp_ticks = TICK_W'(111);
            3'd6:    smp_ticks = TICK_W'(143);
            default: smp_ticks = TICK_W'(479);
        endcase
    endfunction

    // conversion window: twice the converter cycle count
    function automatic logic [TICK_W-1:0] conv_ticks(input logic [1:0] res);
        case (res)
            2'd0:    conv_ticks = TICK_W'(28);
            2'd1:    conv_ticks = TICK_W'(26);
            2'd2:    conv_ticks = TICK_W'(22);
            default: conv_ticks = TICK_W'(18);
        endcase
    endfunction

endpackage

// File: rtl/seq_edge_trig.sv
module seq_edge_trig
    import scan_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       trig_in,
    input  logic [1:0] mode,
    output logic       edge_o
);
    logic prev_q;
    logic rise;
    logic fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= trig_in;
    end

    assign rise = trig_in & ~prev_q;
    assign fall = ~trig_in & prev_q;

    always_comb begin
        unique case (trig_mode_e'(mode))
            TRIG_OFF:  edge_o = 1'b0;
            TRIG_RISE: edge_o = rise;
            TRIG_FALL: edge_o = fall;
            TRIG_BOTH: edge_o = rise | fall;
            default:   edge_o = 1'b0;
        endcase
    end

    AST_TRIG_ONE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |-> (trig_in != prev_q)); // R6
endmodule

// File: rtl/seq_chan_pick.sv
module seq_chan_pick #(
    parameter int NUM_CH = 19,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0] mask,
    input  logic              scan_down,
    input  logic [CH_W-1:0]   cur,
    output logic [CH_W-1:0]   first_ch,
    output logic [CH_W-1:0]   next_ch,
    output logic              has_next,
    output logic              any_set
);
    assign any_set = |mask;

    always_comb begin
        first_ch = '0;
        next_ch  = '0;
        has_next = 1'b0;
        if (!scan_down) begin
            // walk downward so the last hit is the lowest index
            for (int i = NUM_CH - 1; i >= 0; i--) begin
                if (mask[i]) first_ch = CH_W'(i);
                if (mask[i] && (i > int'(cur))) begin
                    next_ch  = CH_W'(i);
                    has_next = 1'b1;
                end
            end
        end else begin
            // walk upward so the last hit is the highest index
            for (int i = 0; i < NUM_CH; i++) begin
                if (mask[i]) first_ch = CH_W'(i);
                if (mask[i] && (i < int'(cur))) begin
                    next_ch  = CH_W'(i);
                    has_next = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/seq_timer.sv
module seq_timer
    import scan_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_smp,
    input  logic       load_conv,
    input  logic [2:0] smp_code,
    input  logic [1:0] res_code,
    output logic       done
);
    logic [TICK_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (load_smp)       cnt_q <= smp_ticks(smp_code) - 1'b1;
        else if (load_conv)      cnt_q <= conv_ticks(res_code) - 1'b1;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);

    AST_CNT_WALKS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_smp && !load_conv && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R4
endmodule

// File: rtl/seq_result.sv
module seq_result #(
    parameter int SMP_W  = 12,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_valid,
    input  logic [SMP_W-1:0]  sample,
    input  logic [1:0]        res_code,
    input  logic              left_align,
    input  logic              ovr_overwrite,
    input  logic              eosmp_set,
    input  logic              eos_set,
    input  logic              rd_data,
    input  logic [2:0]        flag_clr,
    input  logic [3:0]        irq_en,
    output logic [DATA_W-1:0] data_o,
    output logic              eosmp_o,
    output logic              eoc_o,
    output logic              eos_o,
    output logic              ovr_o,
    output logic              irq_o
);
    logic [DATA_W-1:0] data_q;
    logic [DATA_W-1:0] aligned;
    logic [DATA_W-1:0] right_w;
    logic [3:0]        drop;
    logic              eosmp_q, eoc_q, eos_q, ovr_q;
    logic              collide;

    assign drop    = {1'b0, res_code, 1'b0};
    assign right_w = DATA_W'(sample >> drop);

    always_comb begin
        if (left_align) aligned = right_w << (DATA_W - SMP_W + int'(drop));
        else            aligned = right_w;
    end

    // a new result meets an unread one (a read in the same cycle consumes it)
    assign collide = res_valid && eoc_q && !rd_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q  <= '0;
            eosmp_q <= 1'b0;
            eoc_q   <= 1'b0;
            eos_q   <= 1'b0;
            ovr_q   <= 1'b0;
        end else begin
            if (res_valid && (!collide || ovr_overwrite)) data_q <= aligned;

            if (res_valid)    eoc_q <= 1'b1;
            else if (rd_data) eoc_q <= 1'b0;

            if (eosmp_set)        eosmp_q <= 1'b1;
            else if (flag_clr[0]) eosmp_q <= 1'b0;

            if (eos_set)          eos_q <= 1'b1;
            else if (flag_clr[1]) eos_q <= 1'b0;

            if (collide)          ovr_q <= 1'b1;
            else if (flag_clr[2]) ovr_q <= 1'b0;
        end
    end

    assign data_o  = data_q;
    assign eosmp_o = eosmp_q;
    assign eoc_o   = eoc_q;
    assign eos_o   = eos_q;
    assign ovr_o   = ovr_q;
    assign irq_o   = |({ovr_q, eos_q, eoc_q, eosmp_q} & irq_en);

    AST_OVR_PRESERVE: assert property (@(posedge clk) disable iff (!rst_n)
        (collide && !ovr_overwrite) |=> $stable(data_q)); // R9
    AST_OVR_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        collide |=> ovr_q); // R9
    AST_EOC_ON_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> eoc_q); // R10
endmodule

// File: rtl/scan_seq_ctrl.sv
module scan_seq_ctrl
    import scan_seq_pkg::*;
#(
    parameter int NUM_CH = 19,
    parameter int SMP_W  = 12,
    parameter int DATA_W = 16,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] cfg_mask,
    input  logic              cfg_scan_down,
    input  logic [1:0]        cfg_trig_mode,
    input  logic [1:0]        cfg_res,
    input  logic [2:0]        cfg_smp_code,
    input  logic              cfg_cont,
    input  logic              cfg_ovr_overwrite,
    input  logic              cfg_left_align,
    input  logic [3:0]        irq_en,
    input  logic              sw_start,
    input  logic              sw_stop,
    input  logic              hw_trig,
    input  logic              rd_data,
    input  logic [2:0]        flag_clr,
    input  logic [SMP_W-1:0]  sample_in,
    output logic [CH_W-1:0]   cur_chan,
    output logic              busy,
    output logic [DATA_W-1:0] data_out,
    output logic              flag_eosmp,
    output logic              flag_eoc,
    output logic              flag_eos,
    output logic              flag_ovr,
    output logic              irq
);
    seq_state_e        state_q, state_d;
    logic [CH_W-1:0]   chan_q, chan_d;
    logic [NUM_CH-1:0] mask_q;
    logic              down_q;
    logic              latch;

    logic              trig_edge, start_req;
    logic [NUM_CH-1:0] mask_sel;
    logic              down_sel;
    logic [CH_W-1:0]   first_ch, next_ch;
    logic              has_next, any_set;
    logic              load_smp, load_conv, tmr_done;
    logic              res_valid, eosmp_set, eos_set;

    seq_edge_trig u_trig (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig_in(hw_trig),
        .mode   (cfg_trig_mode),
        .edge_o (trig_edge)
    );

    assign start_req = sw_start | trig_edge;
    assign mask_sel  = (state_q == ST_IDLE) ? cfg_mask      : mask_q;
    assign down_sel  = (state_q == ST_IDLE) ? cfg_scan_down : down_q;

    seq_chan_pick #(.NUM_CH(NUM_CH)) u_pick (
        .mask     (mask_sel),
        .scan_down(down_sel),
        .cur      (chan_q),
        .first_ch (first_ch),
        .next_ch  (next_ch),
        .has_next (has_next),
        .any_set  (any_set)
    );

    seq_timer u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_smp (load_smp),
        .load_conv(load_conv),
        .smp_code (cfg_smp_code),
        .res_code (cfg_res),
        .done     (tmr_done)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and control strobes
    always_comb begin
        state_d   = state_q;
        chan_d    = chan_q;
        latch     = 1'b0;
        load_smp  = 1'b0;
        load_conv = 1'b0;
        res_valid = 1'b0;
        eosmp_set = 1'b0;
        eos_set   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_req && !sw_stop) begin
                    latch = 1'b1;
                    if (any_set) begin
                        chan_d   = first_ch;
                        load_smp = 1'b1;
                        state_d  = ST_SAMPLE;
                    end else begin
                        eos_set  = 1'b1;
                    end
                end
            end
            ST_SAMPLE: begin
                if (sw_stop) begin
                    state_d = ST_IDLE;
                end else if (tmr_done) begin
                    eosmp_set = 1'b1;
                    load_conv = 1'b1;
                    state_d   = ST_CONVERT;
                end
            end
            ST_CONVERT: begin
                if (sw_stop) begin
                    state_d = ST_IDLE;
                end else if (tmr_done) begin
                    res_valid = 1'b1;
                    if (has_next) begin
                        chan_d   = next_ch;
                        load_smp = 1'b1;
                        state_d  = ST_SAMPLE;
                    end else begin
                        eos_set = 1'b1;
                        if (cfg_cont) begin
                            chan_d   = first_ch;
                            load_smp = 1'b1;
                            state_d  = ST_SAMPLE;
                        end else begin
                            state_d  = ST_IDLE;
                        end
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chan_q <= '0;
            mask_q <= '0;
            down_q <= 1'b0;
        end else begin
            chan_q <= chan_d;
            if (latch) begin
                mask_q <= cfg_mask;
                down_q <= cfg_scan_down;
            end
        end
    end

    seq_result #(.SMP_W(SMP_W), .DATA_W(DATA_W)) u_res (
        .clk          (clk),
        .rst_n        (rst_n),
        .res_valid    (res_valid),
        .sample       (sample_in),
        .res_code     (cfg_res),
        .left_align   (cfg_left_align),
        .ovr_overwrite(cfg_ovr_overwrite),
        .eosmp_set    (eosmp_set),
        .eos_set      (eos_set),
        .rd_data      (rd_data),
        .flag_clr     (flag_clr),
        .irq_en       (irq_en),
        .data_o       (data_out),
        .eosmp_o      (flag_eosmp),
        .eoc_o        (flag_eoc),
        .eos_o        (flag_eos),
        .ovr_o        (flag_ovr),
        .irq_o        (irq)
    );

    assign cur_chan = chan_q;
    assign busy     = (state_q != ST_IDLE);

    AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        sw_stop |=> (state_q == ST_IDLE)); // R8
    AST_CHAN_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> mask_q[chan_q]); // R2
    AST_EOSMP_AT_CONV: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CONVERT && $past(state_q) == ST_SAMPLE) |-> flag_eosmp); // R4
    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SAMPLE && !tmr_done && !sw_stop) |=> (state_q == ST_SAMPLE && $stable(chan_q))); // R12
endmodule

// File: tb/sim_scan_seq_ctrl.sv
module sim_scan_seq_ctrl;
    localparam int CLK_PER = 10;
    localparam int P       = 21;   // smp code 0 (3) + res 11 (18)

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [18:0] cfg_mask = '0;
    logic        cfg_scan_down = 1'b0;
    logic [1:0]  cfg_trig_mode = 2'b00;
    logic [1:0]  cfg_res = 2'b11;
    logic [2:0]  cfg_smp_code = 3'd0;
    logic        cfg_cont = 1'b0;
    logic        cfg_ovr_overwrite = 1'b0;
    logic        cfg_left_align = 1'b0;
    logic [3:0]  irq_en = '0;
    logic        sw_start = 1'b0;
    logic        sw_stop = 1'b0;
    logic        hw_trig = 1'b0;
    logic        rd_data = 1'b0;
    logic [2:0]  flag_clr = '0;
    logic [11:0] sample_in;
    logic [4:0]  cur_chan;
    logic        busy;
    logic [15:0] data_out;
    logic        flag_eosmp, flag_eoc, flag_eos, flag_ovr, irq;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PER/2) clk = ~clk;

    function automatic int fval(input int ch);
        return ch * 200 + 37;
    endfunction

    assign sample_in = 12'(fval(int'(cur_chan)));

    scan_seq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cfg_mask(cfg_mask), .cfg_scan_down(cfg_scan_down),
        .cfg_trig_mode(cfg_trig_mode), .cfg_res(cfg_res), .cfg_smp_code(cfg_smp_code),
        .cfg_cont(cfg_cont), .cfg_ovr_overwrite(cfg_ovr_overwrite),
        .cfg_left_align(cfg_left_align), .irq_en(irq_en), .sw_start(sw_start),
        .sw_stop(sw_stop), .hw_trig(hw_trig), .rd_data(rd_data), .flag_clr(flag_clr),
        .sample_in(sample_in), .cur_chan(cur_chan), .busy(busy), .data_out(data_out),
        .flag_eosmp(flag_eosmp), .flag_eoc(flag_eoc), .flag_eos(flag_eos),
        .flag_ovr(flag_ovr), .irq(irq)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic pulse_start;
        sw_start = 1'b1; tick(1); sw_start = 1'b0;
    endtask

    task automatic clear_all;
        flag_clr = 3'b111; rd_data = 1'b1; tick(1);
        flag_clr = 3'b000; rd_data = 1'b0;
    endtask

    function automatic int expect_word(input int ch, input logic left);
        int v;
        v = fval(ch) >> 6;
        return left ? (v << 10) : v;
    endfunction

    // run n results at period P, reading each one
    task automatic scan_and_read(input int n, input int chs [4], input logic left, input string req);
        pulse_start();
        for (int j = 0; j < n; j++) begin
            tick(j == 0 ? P : P - 1);
            check(req, "eoc at due edge", int'(flag_eoc), 1);
            check(req, "result word", int'(data_out), expect_word(chs[j], left));
            if (j < n - 1 && !cfg_cont) check(req, "eos early", int'(flag_eos), 0);
            rd_data = 1'b1; tick(1); rd_data = 1'b0;
        end
    endtask

    task automatic t_reset;
        check("R1", "busy", int'(busy), 0);
        check("R1", "flags", int'({flag_eosmp, flag_eoc, flag_eos, flag_ovr}), 0);
        check("R1", "data", int'(data_out), 0);
        check("R1", "irq", int'(irq), 0);
    endtask

    task automatic t_timing;
        cfg_mask = 19'(1 << 5); cfg_smp_code = 3'd1; cfg_res = 2'b00;
        pulse_start();
        tick(14);
        check("R4", "eosmp one early", int'(flag_eosmp), 0);
        tick(1);
        check("R4", "eosmp due", int'(flag_eosmp), 1);
        tick(27);
        check("R4", "eoc one early", int'(flag_eoc), 0);
        tick(1);
        check("R4", "eoc due", int'(flag_eoc), 1);
        check("R5", "12-bit right word", int'(data_out), fval(5));
        check("R7", "single pass idle", int'(busy), 0);
        rd_data = 1'b1; tick(1); rd_data = 1'b0;
        check("R10", "read clears eoc", int'(flag_eoc), 0);
        clear_all();
        cfg_smp_code = 3'd0; cfg_res = 2'b11;
    endtask

    task automatic t_scan_up;
        cfg_mask = 19'((1 << 2) | (1 << 7) | (1 << 18)); cfg_scan_down = 1'b0;
        scan_and_read(3, '{2, 7, 18, 0}, 1'b0, "R2");
        check("R2", "eos after last", int'(flag_eos), 1);
        check("R7", "idle after pass", int'(busy), 0);
        clear_all();
    endtask

    task automatic t_scan_down;
        cfg_scan_down = 1'b1; cfg_left_align = 1'b1;
        scan_and_read(3, '{18, 7, 2, 0}, 1'b1, "R3");
        check("R5", "left align top bit", int'(data_out[15]), int'(expect_word(2, 1'b1) >> 15));
        cfg_scan_down = 1'b0; cfg_left_align = 1'b0;
        clear_all();
    endtask

    task automatic t_empty;
        cfg_mask = '0;
        pulse_start();
        check("R12", "empty eos", int'(flag_eos), 1);
        check("R12", "empty other flags", int'({flag_eosmp, flag_eoc, flag_ovr}), 0);
        check("R12", "empty idle", int'(busy), 0);
        clear_all();
    endtask

    task automatic t_busy_start;
        cfg_mask = 19'((1 << 3) | (1 << 4));
        pulse_start();
        tick(5);
        sw_start = 1'b1; tick(1); sw_start = 1'b0;
        tick(P - 7);
        check("R12", "no early eoc", int'(flag_eoc), 0);
        tick(1);
        check("R12", "eoc on schedule", int'(flag_eoc), 1);
        check("R12", "first channel kept", int'(data_out), expect_word(3, 1'b0));
        tick(P + 2);
        clear_all();
    endtask

    task automatic trig_case(input logic [1:0] mode, input int exp_rise, input int exp_fall);
        cfg_mask = 19'(1); cfg_trig_mode = mode; tick(1);
        hw_trig = 1'b1; tick(1);
        check("R6", $sformatf("mode %0d rising", mode), int'(busy), exp_rise);
        tick(P + 2);
        hw_trig = 1'b0; tick(1);
        check("R6", $sformatf("mode %0d falling", mode), int'(busy), exp_fall);
        tick(P + 2);
        cfg_trig_mode = 2'b00;
        clear_all();
    endtask

    task automatic t_cont_stop;
        cfg_mask = 19'((1 << 1) | (1 << 4)); cfg_cont = 1'b1;
        scan_and_read(3, '{1, 4, 1, 0}, 1'b0, "R7");
        check("R7", "still running", int'(busy), 1);
        sw_stop = 1'b1; tick(1); sw_stop = 1'b0;
        check("R8", "stop idles", int'(busy), 0);
        tick(2 * P);
        check("R8", "no result after stop", int'(flag_eoc), 0);
        cfg_cont = 1'b0;
        clear_all();
    endtask

    task automatic t_overrun;
        cfg_mask = 19'((1 << 6) | (1 << 9)); cfg_ovr_overwrite = 1'b0;
        pulse_start(); tick(2 * P);
        check("R9", "preserve ovr", int'(flag_ovr), 1);
        check("R9", "preserve keeps old", int'(data_out), expect_word(6, 1'b0));
        clear_all();
        cfg_ovr_overwrite = 1'b1;
        pulse_start(); tick(2 * P);
        check("R9", "overwrite ovr", int'(flag_ovr), 1);
        check("R9", "overwrite takes new", int'(data_out), expect_word(9, 1'b0));
        cfg_ovr_overwrite = 1'b0;
    endtask

    task automatic t_flags_irq;
        irq_en = 4'b0000; tick(1);
        check("R11", "no enables", int'(irq), 0);
        irq_en = 4'b1000; tick(1);
        check("R11", "ovr enable", int'(irq), 1);
        flag_clr = 3'b100; tick(1); flag_clr = 3'b000;
        check("R10", "ovr cleared", int'(flag_ovr), 0);
        check("R10", "eos untouched", int'(flag_eos), 1);
        check("R11", "irq drops", int'(irq), 0);
        irq_en = 4'b0100; tick(1);
        check("R11", "eos enable", int'(irq), 1);
        flag_clr = 3'b010; tick(1); flag_clr = 3'b000;
        check("R10", "eos cleared", int'(flag_eos), 0);
        irq_en = 4'b0010; tick(1);
        check("R11", "eoc enable", int'(irq), 1);
        rd_data = 1'b1; tick(1); rd_data = 1'b0;
        check("R10", "eoc read", int'(flag_eoc), 0);
        irq_en = 4'b0001; tick(1);
        check("R11", "eosmp enable", int'(irq), 1);
        flag_clr = 3'b001; tick(1); flag_clr = 3'b000;
        check("R10", "eosmp cleared", int'(flag_eosmp), 0);
        irq_en = 4'b0000;
    endtask

    initial begin
        #(CLK_PER * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_timing();
        t_scan_up();
        t_scan_down();
        t_empty();
        t_busy_start();
        trig_case(2'b00, 0, 0);
        trig_case(2'b01, 1, 0);
        trig_case(2'b10, 0, 1);
        trig_case(2'b11, 1, 1);
        t_cont_stop();
        t_overrun();
        t_flags_irq();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule